// File: doc/BRIEF.md
# Unsigned Divide Unit with Condition Flags

This block carries out unsigned integer division for a 32-bit execute stage. One pulse on `start` latches a dividend, a divisor, two destination register indices and a full/half-word mode bit. The unit then iterates one quotient bit per cycle with a radix-2 restoring algorithm. When it finishes, it raises `done` for one cycle. In that cycle it presents the quotient, the remainder, a write enable for each destination, and a strobe with new overflow, sign and zero flags.

The quotient is meant for the register that supplied the dividend, and the remainder for a second register. A zero divisor is caught in the start cycle and completes at once. In that case it raises only the flag strobe with overflow set, and it hands back the caller's sign and zero values unchanged. Carry and saturation are not driven, so the surrounding flag register keeps them. In halfword mode only the low half of the divisor takes part. When both destination indices are equal, only the remainder is written.

Top module: `udiv_flags_unit`

## Requirements
- R1: On a nonzero divisor, `quo_o` equals dividend / divisor and `rem_o` equals dividend % divisor (unsigned). `quo_we_o` targets `quo_idx_o` and `rem_we_o` targets `rem_idx_o`; both indices are the values latched at start.
- R2: When `half_mode` is 1, only divisor bits [15:0] are used (0x00010006 acts as 6), and the dividend stays 32 bits wide.
- R3: A divisor of zero (after the R2 masking) asserts `flag_we_o` with `ovf_o`=1. Both write enables stay 0, and `sgn_o`/`zer_o` echo the `sgn_i`/`zer_i` values latched at start.
- R4: A zero dividend with a nonzero divisor is a normal divide: quotient 0, remainder 0, `zer_o`=1, both registers written.
- R5: On a normal divide, `zer_o` is 1 exactly when the quotient is 0, whatever the remainder is.
- R6: On a normal divide, `ovf_o`=0 and `sgn_o` equals quotient bit 31.
- R7: When the two latched destination indices are equal, `quo_we_o` stays 0 and only the remainder is written.
- R8: `start` is sampled only while `busy_o` is 0. `busy_o` is 1 from the cycle after the sampled start through the `done_o` cycle. A normal divide raises `done_o` 33 cycles after the sampled edge. A `start` while busy has no effect on the result.
- R9: A zero-divisor operation raises `done_o` in the first cycle after the sampled start.
- R10: `quo_we_o`, `rem_we_o` and `flag_we_o` are 1 only in the cycle where `done_o` is 1. `flag_we_o` is 1 in every such cycle. After reset, `busy_o`, `done_o` and all strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a divide when idle |
| half_mode | input | 1 | 1: use only divisor bits [15:0] |
| dividend_i | input | 32 | Dividend |
| divisor_i | input | 32 | Divisor |
| quo_idx_i | input | 5 | Quotient destination index |
| rem_idx_i | input | 5 | Remainder destination index |
| sgn_i | input | 1 | Current sign flag |
| zer_i | input | 1 | Current zero flag |
| busy_o | output | 1 | Operation in flight |
| done_o | output | 1 | Result cycle |
| quo_o | output | 32 | Quotient |
| rem_o | output | 32 | Remainder |
| quo_we_o | output | 1 | Quotient write enable |
| quo_idx_o | output | 5 | Quotient write index |
| rem_we_o | output | 1 | Remainder write enable |
| rem_idx_o | output | 5 | Remainder write index |
| flag_we_o | output | 1 | Flag update strobe |
| ovf_o | output | 1 | New overflow flag |
| sgn_o | output | 1 | New sign flag |
| zer_o | output | 1 | New zero flag |

## Verification
The assertions assume that the operands, indices and incoming flags only need to be valid in the cycle where `start` is sampled while idle. They also assume that `start` may be asserted at any time, including while busy. The bench drives operands only together with a start pulse. It deliberately pulses `start` with different operands in the middle of a divide, and it toggles `sgn_i`/`zer_i` around zero-divisor operations. This shows that only the values latched at start reach the flags.

// File: rtl/udiv_pkg.sv
package udiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } div_state_e;

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zer;
  } div_flags_t;
endpackage

// File: rtl/udiv_ctrl.sv
module udiv_ctrl
  import udiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic zero_div,
  output logic load,
  output logic step,
  output logic fin,
  output logic busy
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  div_state_e state_q, state_d;
  logic [CW-1:0] cnt_q;

  assign load = (state_q == ST_IDLE) && start;
  assign step = (state_q == ST_RUN);
  assign fin  = (state_q == ST_FIN);
  assign busy = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start) state_d = zero_div ? ST_FIN : ST_RUN;
      ST_RUN:  if (cnt_q == LAST) state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (load)      cnt_q <= '0;
      else if (step) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/udiv_core.sv
module udiv_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  logic [W-1:0] part_q, shq_q, dvs_q;
  logic [2*W-1:0] nxt;

  // One restoring iteration: shift in the next dividend bit, try a subtract,
  // keep the difference only when it does not borrow.
  function automatic logic [2*W-1:0] restore_step(input logic [W-1:0] part,
                                                  input logic [W-1:0] shq,
                                                  input logic [W-1:0] dvs);
    logic [W:0] shifted, diff;
    shifted = {part, shq[W-1]};
    diff    = shifted - {1'b0, dvs};
    if (diff[W]) restore_step = {shifted[W-1:0], shq[W-2:0], 1'b0};
    else         restore_step = {diff[W-1:0],    shq[W-2:0], 1'b1};
  endfunction

  assign nxt = restore_step(part_q, shq_q, dvs_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      part_q <= '0;
      shq_q  <= '0;
      dvs_q  <= '0;
    end else if (load) begin
      part_q <= '0;
      shq_q  <= dividend;
      dvs_q  <= divisor;
    end else if (step) begin
      part_q <= nxt[2*W-1:W];
      shq_q  <= nxt[W-1:0];
    end
  end

  assign quo = shq_q;
  assign rem = part_q;
endmodule

// File: rtl/udiv_result.sv
module udiv_result
  import udiv_pkg::*;
#(
  parameter int W  = 32,
  parameter int IW = 5
) (
  input  logic          fin,
  input  logic          zero_div,
  input  logic [W-1:0]  quo,
  input  logic [IW-1:0] qidx,
  input  logic [IW-1:0] ridx,
  input  logic          sgn_keep,
  input  logic          zer_keep,
  output logic          quo_we,
  output logic          rem_we,
  output logic          flag_we,
  output div_flags_t    flags
);
  function automatic div_flags_t make_flags(input logic dz, input logic [W-1:0] q,
                                            input logic s_old, input logic z_old);
    div_flags_t f;
    if (dz) begin
      f.ovf = 1'b1;
      f.sgn = s_old;
      f.zer = z_old;
    end else begin
      f.ovf = 1'b0;
      f.sgn = q[W-1];
      f.zer = (q == '0);
    end
    return f;
  endfunction

  assign flags   = make_flags(zero_div, quo, sgn_keep, zer_keep);
  assign flag_we = fin;
  assign rem_we  = fin && !zero_div;
  assign quo_we  = fin && !zero_div && (qidx != ridx);
endmodule

// File: rtl/udiv_flags_unit.sv
module udiv_flags_unit
  import udiv_pkg::*;
#(
  parameter int W  = 32,
  parameter int IW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          half_mode,
  input  logic [W-1:0]  dividend_i,
  input  logic [W-1:0]  divisor_i,
  input  logic [IW-1:0] quo_idx_i,
  input  logic [IW-1:0] rem_idx_i,
  input  logic          sgn_i,
  input  logic          zer_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [W-1:0]  quo_o,
  output logic [W-1:0]  rem_o,
  output logic          quo_we_o,
  output logic [IW-1:0] quo_idx_o,
  output logic          rem_we_o,
  output logic [IW-1:0] rem_idx_o,
  output logic          flag_we_o,
  output logic          ovf_o,
  output logic          sgn_o,
  output logic          zer_o
);
  localparam int HW = W / 2;

  logic [W-1:0]  div_eff;
  logic          zero_now;
  logic          load, step, fin;
  logic          dz_q, sgn_q, zer_q;
  logic [IW-1:0] qidx_q, ridx_q;
  logic [W-1:0]  div_q;
  div_flags_t    flags;

  assign div_eff  = half_mode ? {{(W-HW){1'b0}}, divisor_i[HW-1:0]} : divisor_i;
  assign zero_now = (div_eff == '0);

  udiv_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .zero_div(zero_now),
    .load(load), .step(step), .fin(fin), .busy(busy_o)
  );

  udiv_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .dividend(dividend_i), .divisor(div_eff), .quo(quo_o), .rem(rem_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dz_q   <= 1'b0;
      sgn_q  <= 1'b0;
      zer_q  <= 1'b0;
      qidx_q <= '0;
      ridx_q <= '0;
      div_q  <= '0;
    end else if (load) begin
      dz_q   <= zero_now;
      sgn_q  <= sgn_i;
      zer_q  <= zer_i;
      qidx_q <= quo_idx_i;
      ridx_q <= rem_idx_i;
      div_q  <= div_eff;
    end
  end

  udiv_result #(.W(W), .IW(IW)) u_res (
    .fin(fin), .zero_div(dz_q), .quo(quo_o), .qidx(qidx_q), .ridx(ridx_q),
    .sgn_keep(sgn_q), .zer_keep(zer_q),
    .quo_we(quo_we_o), .rem_we(rem_we_o), .flag_we(flag_we_o), .flags(flags)
  );

  assign done_o    = fin;
  assign quo_idx_o = qidx_q;
  assign rem_idx_o = ridx_q;
  assign ovf_o     = flags.ovf;
  assign sgn_o     = flags.sgn;
  assign zer_o     = flags.zer;
endmodule

// File: rtl/udiv_flags_sva.sv
module udiv_flags_sva #(
  parameter int W  = 32,
  parameter int IW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          zero_now,
  input logic [W-1:0]  div_q,
  input logic          busy_o,
  input logic          done_o,
  input logic [W-1:0]  quo_o,
  input logic [W-1:0]  rem_o,
  input logic          quo_we_o,
  input logic [IW-1:0] quo_idx_o,
  input logic          rem_we_o,
  input logic [IW-1:0] rem_idx_o,
  input logic          flag_we_o,
  input logic          ovf_o,
  input logic          sgn_o,
  input logic          zer_o
);
  a_r1_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    rem_we_o |-> rem_o < div_q);

  a_r3_zero_div_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we_o && ovf_o) |-> (!quo_we_o && !rem_we_o));

  a_r5_zero_follows_quotient: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we_o && !ovf_o) |-> (zer_o == (quo_o == '0)));

  a_r6_sign_from_quotient: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we_o && !ovf_o) |-> (sgn_o == quo_o[W-1]));

  a_r7_same_dest_remainder_only: assert property (@(posedge clk) disable iff (!rst_n)
    quo_we_o |-> (quo_idx_o != rem_idx_o));

  a_r8_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_o) |=> busy_o);

  a_r8_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!busy_o && !done_o));

  a_r9_zero_div_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_o && zero_now) |=> (done_o && ovf_o));

  a_r10_strobes_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    (quo_we_o || rem_we_o || flag_we_o) |-> done_o);

  a_r10_flag_strobe_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (flag_we_o && busy_o));
endmodule

bind udiv_flags_unit udiv_flags_sva #(.W(W), .IW(IW)) u_sva (
  .clk(clk), .rst_n(rst_n), .start(start), .zero_now(zero_now), .div_q(div_q),
  .busy_o(busy_o), .done_o(done_o), .quo_o(quo_o), .rem_o(rem_o),
  .quo_we_o(quo_we_o), .quo_idx_o(quo_idx_o), .rem_we_o(rem_we_o),
  .rem_idx_o(rem_idx_o), .flag_we_o(flag_we_o), .ovf_o(ovf_o),
  .sgn_o(sgn_o), .zer_o(zer_o)
);

// File: tb/tb_udiv_flags_unit.sv
`timescale 1ns/1ps
module tb_udiv_flags_unit;
  localparam int W = 32;
  localparam int IW = 5;
  localparam int NV = 10;

  // {dividend, divisor, half}
  localparam logic [64:0] VEC [NV] = '{
    {32'd45,         32'd6,          1'b0},
    {32'h4000_0000,  32'd4,          1'b0},
    {32'd45,         32'h0001_0006,  1'b1},
    {32'd0,          32'd45,         1'b0},
    {32'd16,         32'd45,         1'b0},
    {32'hDEAD_BEEF,  32'd1,          1'b0},
    {32'hFFFF_FFFF,  32'hFFFF_FFFF,  1'b0},
    {32'h1234_5678,  32'hFFFF_FFFF,  1'b0},
    {32'hFFFF_FFFF,  32'd3,          1'b0},
    {32'h8000_0001,  32'h7FFF_0002,  1'b1}
  };

  logic clk = 0, rst_n = 0, start = 0, half_mode = 0, sgn_i = 0, zer_i = 0;
  logic [W-1:0] dividend_i = '0, divisor_i = '0;
  logic [IW-1:0] quo_idx_i = '0, rem_idx_i = '0;
  logic busy_o, done_o, quo_we_o, rem_we_o, flag_we_o, ovf_o, sgn_o, zer_o;
  logic [W-1:0] quo_o, rem_o;
  logic [IW-1:0] quo_idx_o, rem_idx_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  udiv_flags_unit #(.W(W), .IW(IW)) dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] d, input logic h,
                        input logic [IW-1:0] qi, input logic [IW-1:0] ri,
                        input logic si, input logic zi, input bit poke);
    logic [W-1:0] de, eq, er;
    int n;
    de = h ? {16'h0, d[15:0]} : d;
    @(negedge clk);
    dividend_i = a; divisor_i = d; half_mode = h;
    quo_idx_i = qi; rem_idx_i = ri; sgn_i = si; zer_i = zi; start = 1;
    @(negedge clk);
    start = 0;
    dividend_i = ~a; divisor_i = 32'd7; quo_idx_i = ~qi; rem_idx_i = ~ri;
    sgn_i = ~si; zer_i = ~zi; half_mode = ~h;
    n = 1;
    while (!done_o && n < 100) begin
      if (poke && n == 5) start = 1;
      @(negedge clk);
      start = 0;
      n++;
    end
    if (de == '0) begin
      chk(n == 1, "R9 zero-divisor latency", W'(n), 1);
      chk(flag_we_o && ovf_o, "R3 ovf strobe", {flag_we_o, ovf_o}, 2'b11);
      chk(!quo_we_o && !rem_we_o, "R3 no writes", {quo_we_o, rem_we_o}, 0);
      chk(sgn_o == si && zer_o == zi, "R3 sign/zero kept", {sgn_o, zer_o}, {si, zi});
    end else begin
      eq = a / de; er = a % de;
      chk(n == 33, "R8 latency", W'(n), 33);
      chk(quo_o == eq, h ? "R2 quotient" : "R1 quotient", quo_o, eq);
      chk(rem_o == er, h ? "R2 remainder" : "R1 remainder", rem_o, er);
      chk(rem_we_o && rem_idx_o == ri, "R1 remainder write", {rem_we_o, rem_idx_o}, {1'b1, ri});
      chk(quo_we_o == (qi != ri), "R7 quotient write enable", quo_we_o, (qi != ri));
      chk(quo_idx_o == qi, "R1 quotient index", quo_idx_o, qi);
      chk(flag_we_o && !ovf_o, "R6 ovf clear", {flag_we_o, ovf_o}, 2'b10);
      chk(sgn_o == eq[W-1], "R6 sign", sgn_o, eq[W-1]);
      chk(zer_o == (eq == '0), "R5 zero from quotient", zer_o, (eq == '0));
    end
    @(negedge clk);
    chk(!done_o && !busy_o && !quo_we_o && !rem_we_o && !flag_we_o,
        "R10 strobes drop after done", {done_o, busy_o, flag_we_o}, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !flag_we_o && !quo_we_o && !rem_we_o,
        "R10 reset state", {busy_o, done_o, flag_we_o}, 0);
    rst_n = 1;
    for (int i = 0; i < NV; i++)
      run_op(VEC[i][64:33], VEC[i][32:1], VEC[i][0], 5'd2, 5'd3, 1'b0, 1'b0, 0);
    // R4 zero dividend
    run_op(32'd0, 32'd9, 1'b0, 5'd4, 5'd5, 1'b0, 1'b0, 0);
    // R3 / R9 zero divisor with both flag states, and halfword masking to zero
    run_op(32'd45, 32'd0, 1'b0, 5'd2, 5'd3, 1'b0, 1'b0, 0);
    run_op(32'd45, 32'd0, 1'b0, 5'd2, 5'd3, 1'b1, 1'b1, 0);
    run_op(32'd45, 32'h0003_0000, 1'b1, 5'd2, 5'd3, 1'b1, 1'b0, 0);
    // R2 same operand in full mode divides by the whole value
    run_op(32'hFFFF_FFFF, 32'h0001_0006, 1'b0, 5'd2, 5'd3, 1'b0, 1'b0, 0);
    // R7 equal destinations
    run_op(32'd45, 32'd6, 1'b0, 5'd2, 5'd2, 1'b0, 1'b0, 0);
    // R8 start while busy is ignored
    run_op(32'd1000, 32'd7, 1'b0, 5'd8, 5'd9, 1'b0, 1'b0, 1);
    for (int i = 0; i < 40; i++)
      run_op($urandom, $urandom >> (i % 32), i[0], 5'($urandom), 5'($urandom),
             1'b0, 1'b1, 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule